// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a memory-mapped watchdog with an 8-bit up-counter. A prescaler divides the peripheral clock by one of eight ratios and drives the counter. Software guards against hangs by reloading the counter before it wraps. In watchdog mode, a wrap from 255 to 0 latches an overflow flag. If resets are enabled, the same wrap also drives a fixed-length system reset pulse. Loading 255 with the fastest ratio is the quick way to force a restart, because one prescaled tick then remains before the wrap.

There are three 16-bit registers on a plain single-cycle register bus. Each write carries a key in its upper byte, and a write whose key does not match changes nothing. Every access completes in the cycle it is presented. There is no valid/ready handshake, so the bus can never be stalled. Read data is combinational from the address. The read strobe matters for one reason only: the overflow flag can be cleared only after it has been observed. The clear needs a read of the reset control register while the flag is set, followed by a write of the dedicated clear word.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, all three registers read 0x0000 and `sys_rst_out` is low.
- R2: A write at offset 0 takes effect only when bits 15:8 are 0xA5. It then loads bit 6 (watchdog mode), bit 5 (run) and bits 2:0 (divider code). A read at offset 0 returns those bits in the same positions, with every other bit at 0. A write with any other key changes nothing.
- R3: A write at offset 2 with key 0x5A loads bits 7:0 into the counter and restarts the prescaler. A read at offset 2 returns the counter in bits 7:0. A write with any other key changes nothing.
- R4: A write at offset 4 with key 0x5A sets the reset-enable bit from bit 6. A read at offset 4 returns the overflow flag in bit 7 and reset-enable in bit 6.
- R5: While running, the counter advances once every N clocks, starting N clocks after the run bit is set. Divider codes 0 to 7 give N = 1, 4, 16, 32, 64, 256, 1024 and 16384.
- R6: While the timer is stopped, the counter holds its value. Stopping the timer restarts the prescaler, so a later start counts a full period.
- R7: In watchdog mode, a wrap from 255 to 0 sets the overflow flag. If reset-enable is also set, the wrap raises `sys_rst_out`. With 255 loaded and code 0, the pulse starts one clock after the run bit is set.
- R8: `sys_rst_out` stays high for exactly 16 clocks. A wrap during an active pulse does not extend it.
- R9: In interval mode (bit 6 clear), the counter wraps without setting the flag and without asserting a reset.
- R10: Writing 0x A500 at offset 4 clears the overflow flag only if offset 4 was read while the flag was set. The clear word does not change reset-enable. A clear attempt that is not armed has no effect.
- R11: A new wrap that sets the flag cancels any earlier read, so software must read the flag again before a clear will take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data: key in bits 15:8, payload in bits 7:0 |
| bus_re | input | 1 | Read strobe, used to arm the flag clear |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| sys_rst_out | output | 1 | System reset pulse |

## Verification
The bench probes the boundaries of prescaler phase. It reads the counter exactly one clock before and at the moment a 1024-clock tick lands. It also confirms that both a stop/start and a counter reload restart the phase. A design that kept the phase across either event would read one count high. The clear handshake is tested three ways: a clear with no prior read, a read followed by a second wrap, and a proper read then clear. A design that ignored the arming rule, or let an old read survive a new wrap, would drop the flag too early. The pulse is checked on its first and sixteenth cycles and on the cycle after. Wraps in interval mode and with resets disabled are checked to leave the reset pin low.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 3;
  localparam int NCODE  = 1 << SEL_W;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_RSTC = 3'd4;

  localparam logic [7:0]  KEY_CTRL  = 8'hA5;
  localparam logic [7:0]  KEY_CNT   = 8'h5A;
  localparam logic [7:0]  KEY_RSTC  = 8'h5A;
  localparam logic [15:0] WORD_CLR  = 16'hA500;

  typedef struct packed {
    logic             wd;
    logic             run;
    logic [SEL_W-1:0] div;
  } ctrl_t;

  function automatic int unsigned div_log2(input int unsigned code);
    case (code)
      0:       return 0;
      1:       return 2;
      2:       return 4;
      3:       return 5;
      4:       return 6;
      5:       return 8;
      6:       return 10;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              flag_evt,
  output logic [DATA_W-1:0] bus_rdata,
  output ctrl_t             ctrl,
  output logic              rste,
  output logic              ovf,
  output logic              armed,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_ldval
);
  localparam int KEY_LSB = DATA_W - 8;

  logic [7:0] key;
  logic       at_ctrl, at_cnt, at_rstc;
  logic       ctrl_wr, rstc_wr, clr_wr, rstc_rd;

  assign key      = bus_wdata[DATA_W-1:KEY_LSB];
  assign at_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign at_cnt   = (bus_addr == ADDR_W'(OFS_CNT));
  assign at_rstc  = (bus_addr == ADDR_W'(OFS_RSTC));

  assign ctrl_wr  = bus_we && at_ctrl && (key == KEY_CTRL);
  assign cnt_load = bus_we && at_cnt  && (key == KEY_CNT);
  assign rstc_wr  = bus_we && at_rstc && (key == KEY_RSTC);
  assign clr_wr   = bus_we && at_rstc && (bus_wdata == WORD_CLR);
  assign rstc_rd  = bus_re && at_rstc;
  assign cnt_ldval = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      rste <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl.wd  <= bus_wdata[6];
        ctrl.run <= bus_wdata[5];
        ctrl.div <= bus_wdata[SEL_W-1:0];
      end
      if (rstc_wr) rste <= bus_wdata[6];
    end
  end

  // Flag and its read-arm: a fresh set wins over a clear and drops any arm.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf   <= 1'b0;
      armed <= 1'b0;
    end else if (flag_evt) begin
      ovf   <= 1'b1;
      armed <= 1'b0;
    end else if (clr_wr && armed) begin
      ovf   <= 1'b0;
      armed <= 1'b0;
    end else if (rstc_rd && ovf) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (at_ctrl) begin
      bus_rdata[6]         = ctrl.wd;
      bus_rdata[5]         = ctrl.run;
      bus_rdata[SEL_W-1:0] = ctrl.div;
    end else if (at_cnt) begin
      bus_rdata[CNT_W-1:0] = cnt_val;
    end else if (at_rstc) begin
      bus_rdata[7] = ovf;
      bus_rdata[6] = rste;
    end
  end
endmodule

// File: rtl/wdt_keyed_presc.sv
module wdt_keyed_presc
  import wdt_keyed_pkg::*;
#(
  parameter int PRE_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             restart,
  output logic             tick
);
  logic [PRE_W-1:0] phase;
  logic [NCODE-1:0] hit;

  for (genvar g = 0; g < NCODE; g++) begin : g_lim
    localparam int unsigned LIM = (32'd1 << div_log2(g)) - 32'd1;
    assign hit[g] = (phase >= LIM[PRE_W-1:0]);
  end

  assign tick = run && hit[div_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase <= '0;
    else if (!run || restart || tick) phase <= '0;
    else                            phase <= phase + 1'b1;
  end
endmodule

// File: rtl/wdt_keyed_count.sv
module wdt_keyed_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && !load && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_keyed_pulse.sv
module wdt_keyed_pulse #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] left;

  assign pulse = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (pulse)        left <= left - 1'b1;
    else if (fire)         left <= HW'(HOLD);
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 14,
  parameter int HOLD   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_re,
  output logic [15:0]       bus_rdata,
  output logic              sys_rst_out
);
  ctrl_t            ctrl;
  logic             rste, ovf_flag, rd_armed;
  logic             cnt_load, tick, wrap, flag_evt, fire;
  logic [CNT_W-1:0] cnt_ldval, cnt_val;

  assign flag_evt = wrap && ctrl.wd;
  assign fire     = flag_evt && rste;

  wdt_keyed_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .cnt_val(cnt_val),
    .flag_evt(flag_evt), .bus_rdata(bus_rdata), .ctrl(ctrl), .rste(rste),
    .ovf(ovf_flag), .armed(rd_armed), .cnt_load(cnt_load),
    .cnt_ldval(cnt_ldval)
  );

  wdt_keyed_presc #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .div_sel(ctrl.div),
    .restart(cnt_load), .tick(tick)
  );

  wdt_keyed_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(cnt_ldval), .cnt(cnt_val), .wrap(wrap)
  );

  wdt_keyed_pulse #(.HOLD(HOLD)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(sys_rst_out)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              sys_rst_out,
  input logic              ctrl_wd,
  input logic              ctrl_run,
  input logic [2:0]        ctrl_div,
  input logic              ovf_flag,
  input logic              rd_armed,
  input logic              rste,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              cnt_load
);
  logic [5:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_q <= '0;
    else if (sys_rst_out) hi_q <= hi_q + 1'b1;
    else                  hi_q <= '0;
  end

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_out) |-> (hi_q == 6'd16));

  // R8
  pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_out |-> (hi_q < 6'd16));

  // R6
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_run && !cnt_load) |=> $stable(cnt_val));

  // R2
  bad_key_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0 && bus_wdata[15:8] != 8'hA5)
    |=> ($stable(ctrl_wd) && $stable(ctrl_run) && $stable(ctrl_div)));

  // R10
  clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(rd_armed));

  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_out) |-> (ovf_flag && $past(rste) && $past(ctrl_wd)));

  // R9
  flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ctrl_wd));
endmodule

bind wdt_keyed wdt_keyed_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sys_rst_out(sys_rst_out), .ctrl_wd(ctrl.wd),
  .ctrl_run(ctrl.run), .ctrl_div(ctrl.div), .ovf_flag(ovf_flag),
  .rd_armed(rd_armed), .rste(rste), .cnt_val(cnt_val), .cnt_load(cnt_load)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic        sys_rst_out;

  always #10 clk = ~clk;

  wdt_keyed u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sys_rst_out(sys_rst_out)
  );

  typedef struct {
    bit          pin;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string t);
    item_t it;
    bus_addr = a; bus_re = 1'b1;
    it.pin = 1'b0; it.exp = e; it.tag = t;
    q.push_back(it);
    step();
    bus_re = 1'b0;
  endtask

  task automatic pin_chk(input logic e, input string t);
    item_t it;
    it.pin = 1'b1; it.exp = {15'b0, e}; it.tag = t;
    q.push_back(it);
  endtask

  // Monitor: pops expectations and compares mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = it.pin ? {15'b0, sys_rst_out} : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    pin_chk(1'b0, "R1 pin");
    rd_chk(3'd0, 16'h0000, "R1 ctrl");
    rd_chk(3'd2, 16'h0000, "R1 cnt");
    rd_chk(3'd4, 16'h0000, "R1 rstc");

    // R2 key handling on control
    wr(3'd0, 16'h0067);
    wr(3'd0, 16'h5A67);
    rd_chk(3'd0, 16'h0000, "R2 bad key");
    wr(3'd0, 16'hA507);
    rd_chk(3'd0, 16'h0007, "R2 good key");

    // R3 / R6 hold while stopped, bad counter key
    wr(3'd2, 16'h5A10);
    repeat (50) step();
    rd_chk(3'd2, 16'h0010, "R6 hold stopped");
    wr(3'd2, 16'hA533);
    rd_chk(3'd2, 16'h0010, "R3 bad key");

    // R5 divider code 1 (4 clocks)
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA521);
    repeat (10) step();
    rd_chk(3'd2, 16'h0002, "R5 div4 count");
    wr(3'd0, 16'hA501);
    rd_chk(3'd2, 16'h0003, "R5 div4 at stop");

    // R6 stop restarts prescaler
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA522);
    repeat (9) step();
    wr(3'd0, 16'hA502);
    wr(3'd0, 16'hA522);
    repeat (9) step();
    rd_chk(3'd2, 16'h0000, "R6 restart on stop");
    // R3 counter write restarts prescaler
    wr(3'd2, 16'h5A05);
    repeat (9) step();
    rd_chk(3'd2, 16'h0005, "R3 restart on load");
    wr(3'd0, 16'hA502);

    // R4 reset enable
    wr(3'd4, 16'h5A40);
    rd_chk(3'd4, 16'h0040, "R4 rste set");

    // R9 interval mode wrap
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA520);
    repeat (3) step();
    pin_chk(1'b0, "R9 no reset");
    rd_chk(3'd2, 16'h0002, "R9 wrapped");
    rd_chk(3'd4, 16'h0040, "R9 no flag");
    wr(3'd0, 16'hA500);

    // R7 / R8 watchdog wrap and pulse width
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    pin_chk(1'b0, "R7 before wrap");
    step();
    pin_chk(1'b1, "R7 pulse start");
    repeat (15) step();
    pin_chk(1'b1, "R8 pulse cycle 16");
    step();
    pin_chk(1'b0, "R8 pulse end");
    wr(3'd0, 16'hA540);
    rd_chk(3'd0, 16'h0040, "R2 wd mode stopped");

    // R10 clear handshake
    wr(3'd4, 16'hA500);
    rd_chk(3'd4, 16'h00C0, "R10 unarmed clear ignored");
    wr(3'd4, 16'hA500);
    rd_chk(3'd4, 16'h0040, "R10 armed clear");

    // R11 new wrap cancels earlier read
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    repeat (20) step();
    wr(3'd0, 16'hA540);
    rd_chk(3'd4, 16'h00C0, "R11 flag set again");
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    repeat (20) step();
    wr(3'd0, 16'hA540);
    wr(3'd4, 16'hA500);
    rd_chk(3'd4, 16'h00C0, "R11 stale read");
    wr(3'd4, 16'hA500);
    rd_chk(3'd4, 16'h0040, "R11 clear after reread");

    // R7 reset disabled: flag only
    wr(3'd4, 16'h5A00);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    for (int i = 0; i < 4; i++) begin
      step();
      pin_chk(1'b0, "R7 rste off no pulse");
    end
    wr(3'd0, 16'hA540);
    rd_chk(3'd4, 16'h0080, "R7 rste off flag");
    wr(3'd4, 16'hA500);
    rd_chk(3'd4, 16'h0000, "R10 clear rste off");

    // R5 slowest code 7
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA567);
    repeat (16383) step();
    pin_chk(1'b0, "R5 div16384 one early");
    step();
    pin_chk(1'b1, "R5 div16384 wrap");
    wr(3'd0, 16'hA507);

    // R5 code 6 tick boundary
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA526);
    repeat (2047) step();
    rd_chk(3'd2, 16'h0001, "R5 div1024 before");
    rd_chk(3'd2, 16'h0002, "R5 div1024 at");
    wr(3'd0, 16'hA506);

    step();
    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule